// File: doc/BRIEF.md
# Shared-Pin Parallel I/O Port

This block is a parallel I/O port of `WIDTH` pins. A small synchronous register bus reaches three registers: a direction register, an output latch and a pin-level register. Every pin may also be claimed by one peripheral. The peripheral brings its own output value, its own output enable and a module enable. The block drives tri-state style pad controls, one output value and one enable per pin. It takes pin levels that have already been synchronized, and it returns a gated copy of those levels to the peripheral.

The port is the fallback owner of each pin. The peripheral wins a pin only while it is enabled and actively driving that pin. A parameter mask marks which bits exist. A bit outside the mask is never driven and always reads back as zero.

When the port drives a pin itself, the value on that pin is the port's own latch. The peripheral input for that bit is then forced to zero, so the port's output cannot loop back into the peripheral.

Top module: `shared_pin_port`

## Requirements
- R1: A direction bit of 1 makes its pin an input (pinOe=0). A direction bit of 0 makes it an output (pinOe=1) that carries the latch bit on pinOut. This holds whenever the peripheral does not own that pin. Writing address 0 loads the direction register.
- R2: After reset the following hold:
  - every implemented direction bit is 1;
  - the latch is 0;
  - pinOe is 0 on every pin;
  - busRdData is 0 until the first read.
- R3: A read of address 2 returns the latch contents, not the pin levels.
- R4: A read of address 1 returns the sampled pin levels (pinIn). A write to address 1 loads the latch exactly as a write to address 2 does.
- R5: The peripheral owns a pin when its perEn bit and its perOe bit are both 1. The pin then has pinOe=1 and pinOut equal to the perOut bit, whatever the direction and latch bits are. A read of address 1 still returns pinIn.
- R6: If only one of the pin's perEn and perOe bits is 1, the direction and latch bits control the pin as in R1.
- R7: For bits that are 0 in `IMPL_MASK`:
  - the direction, latch and pin reads return 0;
  - pinOe, pinOut and perIn are 0;
  - writes have no visible effect.
- R8: perIn equals pinIn on every implemented bit, except on bits that the port drives itself (direction 0 and no peripheral ownership). Those bits are 0.
- R9: busRdData updates on the clock edge where busRdEn is sampled high and is valid from that edge on. Without busRdEn it holds its value.
- R10: A read of address 3 returns 0. A read issued together with a write in the same cycle returns the register value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address: 0 direction, 1 pin levels, 2 latch, 3 unused |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | WIDTH | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | WIDTH | Registered read data |
| pinIn | input | WIDTH | Synchronized pin levels |
| pinOut | output | WIDTH | Pad output value |
| pinOe | output | WIDTH | Pad output enable, 1 drives |
| perOut | input | WIDTH | Peripheral output value |
| perOe | input | WIDTH | Peripheral output enable |
| perEn | input | WIDTH | Peripheral module enable per pin |
| perIn | output | WIDTH | Gated pin levels to the peripheral |

## Verification
Random register traffic runs together with random combinations of perEn, perOe and direction bits. Because the combinations differ bit by bit, one vector mixes port-driven, peripheral-owned, half-enabled and input pins. This separates the ownership rule (R5, R6) from the direction rule (R1), and separates the loop-through gate from plain masking.

Latch and pin reads are made while pinIn differs from the latch, which tells R3 apart from R4. Writes through address 1 are then read back at address 2.

Directed cases cover the following:
- peripheral takeover and release on the same pins;
- a read and a write to the same register in one cycle;
- an idle cycle that must hold busRdData;
- address 3;
- writes of all ones into the unimplemented bits.

// File: rtl/spp_pkg.sv
package spp_pkg;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_PIN  = 2'd1,
    SEL_LAT  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrDir;
    logic    wrLat;
    logic    rdStrobe;
    regSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/spp_ctrl.sv
module spp_ctrl
  import spp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWrEn,
  input  logic       busRdEn,
  output strobe_t    strb
);

  regSel_e addrSel;

  always_comb begin
    addrSel       = regSel_e'(busAddr);
    strb          = '0;
    strb.rdStrobe = busRdEn;
    strb.rdSel    = addrSel;
    if (busWrEn) begin
      unique case (addrSel)
        SEL_DIR:  strb.wrDir = 1'b1;
        SEL_PIN,
        SEL_LAT:  strb.wrLat = 1'b1;
        default:  ;
      endcase
    end
  end

  // R4: a write to the pin address and a write to the latch address both end in the latch
  assert_pin_write_to_lat_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd1) |-> (strb.wrLat && !strb.wrDir));

  // R10: address 3 targets no register
  assert_unused_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd3) |-> !(strb.wrLat || strb.wrDir));

endmodule

// File: rtl/spp_datapath.sv
module spp_datapath
  import spp_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] IMPL_MASK = 16'h7FF7
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  input  logic [WIDTH-1:0] perOut,
  input  logic [WIDTH-1:0] perOe,
  input  logic [WIDTH-1:0] perEn,
  output logic [WIDTH-1:0] perIn
);

  localparam logic [WIDTH-1:0] IMPL = IMPL_MASK;

  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] latReg;
  logic [WIDTH-1:0] rdReg;
  logic [WIDTH-1:0] rdMux;
  logic [WIDTH-1:0] perOwn;
  logic [WIDTH-1:0] portDrive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg <= '1;
      latReg <= '0;
      rdReg  <= '0;
    end else begin
      if (strb.wrDir)    dirReg <= wrData | ~IMPL;
      if (strb.wrLat)    latReg <= wrData & IMPL;
      if (strb.rdStrobe) rdReg  <= rdMux;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_DIR: rdMux = dirReg & IMPL;
      SEL_PIN: rdMux = pinIn & IMPL;
      SEL_LAT: rdMux = latReg & IMPL;
      default: rdMux = '0;
    endcase
  end

  assign rdData = rdReg;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (IMPL[b]) begin : g_live
      always_comb begin
        perOwn[b]    = perEn[b] & perOe[b];
        portDrive[b] = ~dirReg[b] & ~perOwn[b];
        pinOe[b]     = perOwn[b] | portDrive[b];
        pinOut[b]    = perOwn[b] ? perOut[b] : latReg[b];
        perIn[b]     = portDrive[b] ? 1'b0 : pinIn[b];
      end
    end else begin : g_dead
      always_comb begin
        perOwn[b]    = 1'b0;
        portDrive[b] = 1'b0;
        pinOe[b]     = 1'b0;
        pinOut[b]    = 1'b0;
        perIn[b]     = 1'b0;
      end
    end
  end

  // R1: a direction write lands one edge later, with unimplemented bits left as inputs
  assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDir |=> (dirReg == ($past(wrData) | ~IMPL)));

  // R4: a latch write lands one edge later, masked
  assert_lat_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLat |=> (latReg == ($past(wrData) & IMPL)));

  // R3: a latch read returns the pre-edge latch
  assert_lat_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStrobe && strb.rdSel == SEL_LAT) |=> (rdData == $past(latReg & IMPL)));

  // R9: read data holds without a read strobe
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdStrobe |=> $stable(rdData));

endmodule

// File: rtl/shared_pin_port.sv
module shared_pin_port
  import spp_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] IMPL_MASK = 16'h7FF7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWrEn,
  input  logic [WIDTH-1:0] busWrData,
  input  logic             busRdEn,
  output logic [WIDTH-1:0] busRdData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  input  logic [WIDTH-1:0] perOut,
  input  logic [WIDTH-1:0] perOe,
  input  logic [WIDTH-1:0] perEn,
  output logic [WIDTH-1:0] perIn
);

  strobe_t strb;

  spp_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strb    (strb)
  );

  spp_datapath #(
    .WIDTH     (WIDTH),
    .IMPL_MASK (IMPL_MASK)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (busWrData),
    .rdData (busRdData),
    .pinIn  (pinIn),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .perOut (perOut),
    .perOe  (perOe),
    .perEn  (perEn),
    .perIn  (perIn)
  );

  // R8: a pin the port drives itself never echoes into the peripheral
  assert_no_loop_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe & ~(perEn & perOe) & perIn) == '0));

  // R5: peripheral ownership forces the enable and the value
  assert_per_owns_R5: assert property (@(posedge clk) disable iff (!rstN)
    (((perEn & perOe & IMPL_MASK) & ~pinOe) == '0) &&
    (((pinOut ^ perOut) & perEn & perOe & IMPL_MASK) == '0));

  // R7: nothing appears on unimplemented bits
  assert_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (((pinOe | pinOut | perIn | busRdData) & ~IMPL_MASK) == '0));

endmodule

// File: tb/test_shared_pin_port.sv
module test_shared_pin_port;

  localparam int unsigned W = 16;
  localparam logic [W-1:0] M = 16'h7FF7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic busRdEn = 1'b0;
  logic [W-1:0] busWrData = '0;
  logic [W-1:0] busRdData;
  logic [W-1:0] pinIn = '0;
  logic [W-1:0] pinOut;
  logic [W-1:0] pinOe;
  logic [W-1:0] perOut = '0;
  logic [W-1:0] perOe = '0;
  logic [W-1:0] perEn = '0;
  logic [W-1:0] perIn;

  int nChecks = 0;
  int nFails = 0;
  logic finished = 1'b0;
  logic [W-1:0] expDir;
  logic [W-1:0] expLat;

  always #10 clk = ~clk;

  shared_pin_port #(.WIDTH(W), .IMPL_MASK(M)) i_shared_pin_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .perOut(perOut),
    .perOe(perOe), .perEn(perEn), .perIn(perIn)
  );

  function automatic logic [W-1:0] own();
    return perEn & perOe & M;
  endfunction

  function automatic logic [W-1:0] fOe();
    return (own() | (~expDir & ~own())) & M;
  endfunction

  function automatic logic [W-1:0] fOut();
    return ((own() & perOut) | (~own() & expLat)) & M;
  endfunction

  function automatic logic [W-1:0] fIn();
    return pinIn & M & ~(~expDir & ~own());
  endfunction

  function automatic logic [W-1:0] fRead(input logic [1:0] a);
    case (a)
      2'd0:    return expDir & M;
      2'd1:    return pinIn & M;
      2'd2:    return expLat;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkPins(input string tag);
    #2;
    chk({tag, " pinOe"}, pinOe, fOe());
    chk({tag, " pinOut"}, pinOut, fOut());
    chk({tag, " perIn R8"}, perIn, fIn());
  endtask

  task automatic busOp(input logic wr, input logic rd, input logic [1:0] a,
                       input logic [W-1:0] d, input string tag);
    logic [W-1:0] expRd;
    @(negedge clk);
    busAddr = a;
    busWrEn = wr;
    busRdEn = rd;
    busWrData = d;
    expRd = fRead(a);
    @(negedge clk);
    if (wr) begin
      if (a == 2'd0) expDir = d | ~M;
      else if (a != 2'd3) expLat = d & M;
    end
    busWrEn = 1'b0;
    busRdEn = 1'b0;
    if (rd) chk(tag, busRdData, expRd);
  endtask

  task automatic setPer(input logic [W-1:0] en, input logic [W-1:0] oe,
                        input logic [W-1:0] po, input logic [W-1:0] pi);
    @(negedge clk);
    perEn = en;
    perOe = oe;
    perOut = po;
    pinIn = pi;
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd1234));
    expDir = '1;
    expLat = '0;
    repeat (3) @(negedge clk);
    chk("R2 pinOe in reset", pinOe, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 rdData before any read", busRdData, '0);
    chkPins("R2 idle");

    // R2 / R7: reset values read back masked
    busOp(1'b0, 1'b1, 2'd0, '0, "R2 dir reset");
    busOp(1'b0, 1'b1, 2'd2, '0, "R2 lat reset");
    pinIn = 16'hFFFF;
    busOp(1'b0, 1'b1, 2'd1, '0, "R7 pin read masked");
    busOp(1'b0, 1'b1, 2'd3, '0, "R10 unused address");

    // R7: writes of all ones into dead bits stay invisible
    busOp(1'b1, 1'b0, 2'd2, 16'hFFFF, "R7 lat write");
    busOp(1'b1, 1'b0, 2'd0, 16'h0000, "R7 dir write");
    busOp(1'b0, 1'b1, 2'd2, '0, "R7 lat read");
    busOp(1'b0, 1'b1, 2'd0, '0, "R7 dir read");
    chkPins("R1 R7 all outputs");

    // R3 vs R4: latch differs from pins; write through pin address
    pinIn = 16'h0F0F;
    busOp(1'b1, 1'b0, 2'd1, 16'hA5A5, "R4 pin write");
    busOp(1'b0, 1'b1, 2'd2, '0, "R3 latch read after pin write R4");
    busOp(1'b0, 1'b1, 2'd1, '0, "R4 pin read");
    chkPins("R1 driven from latch");

    // R5: takeover on low byte, R6 on half-enabled bits
    setPer(16'hFFFF, 16'h00FF, 16'h3C3C, 16'h5555);
    chkPins("R5 takeover");
    busOp(1'b0, 1'b1, 2'd1, '0, "R5 pin still readable");
    setPer(16'hFFFF, 16'h0000, 16'h3C3C, 16'h5555);
    chkPins("R6 release enabled no oe");
    setPer(16'h0000, 16'hFFFF, 16'h3C3C, 16'h5555);
    chkPins("R6 oe without enable");
    busOp(1'b1, 1'b0, 2'd0, 16'hF0F0, "R1 dir mix");
    setPer(16'h0FF0, 16'h3CC3, 16'hFFFF, 16'hAAAA);
    chkPins("R5 R6 R8 mixed");

    // R10: read and write in one cycle returns the old value
    busOp(1'b1, 1'b1, 2'd2, 16'h1234, "R10 read during write");
    busOp(1'b0, 1'b1, 2'd2, '0, "R3 new latch");
    held = busRdData;
    @(negedge clk);
    @(negedge clk);
    chk("R9 hold without read", busRdData, held);

    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [1:0] a;
      logic wr;
      logic rd;
      a = 2'($urandom_range(3, 0));
      wr = 1'($urandom_range(1, 0));
      rd = 1'($urandom_range(1, 0));
      setPer(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
      chkPins("R1 R5 R6 R8 random");
      busOp(wr, rd, a, 16'($urandom), "R3 R4 R9 R10 random read");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule